// File: doc/BRIEF.md
# Composite Sync Separator

This block accepts a sync input that has already been digitized. The input may be a plain horizontal sync or a composite sync, and its active level is not known in advance. The block finds out which level is the active one and turns every sync into an active-high internal form. From that form it makes a clean one-clock horizontal reference pulse at each accepted leading edge. It also pulls the vertical interval out of composite sync by measuring duty cycle. The horizontal reference goes to a downstream phase comparator, which needs exactly one pulse per line.

The line period comes in as a clock count on a configuration input. The polarity detector compares high time against low time over one full line period and takes the shorter level as the active one. An up/down integrator rises while sync is active and falls while it is not. The vertical output is raised when the integrator passes a quarter of the line period. Leading edges that arrive too soon after the previous reference, such as equalization pulses, are blanked. While the vertical output is high, a missing edge is replaced by a synthesized pulse. A vertical-present flag summarizes whether vertical sync has been seen recently.

Top module: `comp_sync_sep`

## Requirements
- R1: After reset, `h_ref`, `v_sync`, `pol_neg` and `v_present` are all 0.
- R2: Until one full line period has elapsed after reset, `h_ref` and `v_sync` stay 0, whatever the input does.
- R3: At the end of each line-period window, `pol_neg` becomes 1 if the input was high in more than half of the window's cycles, 0 if in fewer than half, and is unchanged on a tie. No update happens while `v_sync` is 1.
- R4: `h_ref` is a single-cycle pulse. It is high in the clock cycle after the edge that first samples an accepted leading edge of the normalized sync, where normalized sync is the input when `pol_neg`=0 and the inverted input when `pol_neg`=1.
- R5: A leading edge is ignored when it is sampled fewer than P - floor(P/4) clocks after the last `h_ref`, where P is `line_period`. With P=64 an edge 47 clocks after the reference is blanked and one 48 clocks after is accepted.
- R6: The integrator counts up on active cycles and down on inactive cycles, saturating at 0 and P. `v_sync` rises when it exceeds floor(P/4). An isolated pulse of width floor(P/4) never raises `v_sync`, while a pulse one clock wider does.
- R7: `v_sync` falls once the integrator has drained to zero.
- R8: While `v_sync` is 1, if P clocks pass after the last `h_ref` with no accepted edge, `h_ref` is synthesized at that point.
- R9: `v_present` is set the cycle after `v_sync` rises. It clears once MISS_LINES `h_ref` pulses have occurred with `v_sync` low since the last vertical interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_in | input | 1 | Digitized sync, either polarity |
| line_period | input | LINE_W | Line period in clocks (at least 4) |
| h_ref | output | 1 | One-clock horizontal reference pulse |
| v_sync | output | 1 | Extracted vertical interval |
| pol_neg | output | 1 | 1 when the active sync level is low |
| v_present | output | 1 | Vertical sync seen recently |

## Verification
The assertions check these properties on every cycle:
- the reference is always a single-cycle pulse;
- the spacing between references never falls below the blanking holdoff;
- both outputs stay quiet until polarity has first been decided;
- polarity holds still throughout a vertical interval;
- the presence flag follows each rising edge of the vertical output.

Some behaviour can only be shown by the bench's scenarios. These cover the direction of the polarity decision, the exact quarter-period width threshold, equalization pulses on either side of the holdoff, the synthesized reference across a missing edge in the vertical interval, and the presence flag clearing after the configured number of lines.

// File: rtl/csep_pkg.sv
// Shared types for the composite sync separator.
package csep_pkg;
    // Which input level is treated as the active sync level.
    typedef enum logic {
        POL_HIGH = 1'b0,
        POL_LOW  = 1'b1
    } pol_e;

    // Smallest line period the thresholds are meaningful for.
    localparam int MIN_PERIOD = 4;
endpackage

// File: rtl/csep_pol_detect.sv
// Polarity detector.
// Counts the cycles the raw input is high over a window of line_period clocks.
// At the end of each window, the level that occupied the shorter share of the
// window is taken as the active level. A tie keeps the previous choice.
// Assumes line_period >= 4. The update is skipped while freeze is high.
// pol_valid rises after the first full window; pol_flip marks a change of choice.
module csep_pol_detect #(
    parameter int LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_in,
    input  logic [LINE_W-1:0] line_period,
    input  logic              freeze,
    output csep_pkg::pol_e    pol_sel,
    output logic              pol_valid,
    output logic              pol_flip
);
    import csep_pkg::*;

    logic [LINE_W-1:0] wnd_cnt;
    logic [LINE_W-1:0] hi_cnt;
    logic [LINE_W:0]   hi_total;
    logic [LINE_W+1:0] hi_twice;
    logic [LINE_W+1:0] per_wide;
    logic              wnd_end;
    pol_e              pol_next;

    // Window bookkeeping and the proposed polarity at the window end.
    always_comb begin
        hi_total = {1'b0, hi_cnt} + {{LINE_W{1'b0}}, sync_in};
        hi_twice = {hi_total, 1'b0};
        per_wide = {2'b00, line_period};
        wnd_end  = (wnd_cnt >= line_period - LINE_W'(1));
        if (hi_twice > per_wide)
            pol_next = POL_LOW;
        else if (hi_twice < per_wide)
            pol_next = POL_HIGH;
        else
            pol_next = pol_sel;
        pol_flip = wnd_end && !freeze && (pol_next != pol_sel);
    end

    // Advance the window and latch the decision at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wnd_cnt   <= '0;
            hi_cnt    <= '0;
            pol_sel   <= POL_HIGH;
            pol_valid <= 1'b0;
        end else if (wnd_end) begin
            wnd_cnt   <= '0;
            hi_cnt    <= '0;
            pol_valid <= 1'b1;
            if (!freeze)
                pol_sel <= pol_next;
        end else begin
            wnd_cnt <= wnd_cnt + LINE_W'(1);
            hi_cnt  <= hi_total[LINE_W-1:0];
        end
    end
endmodule

// File: rtl/csep_integrator.sv
// Duty-cycle integrator.
// Counts up on active cycles and down on inactive ones, saturating at 0 and at
// line_period. The vertical output rises when the count passes a quarter of
// the line period and falls when the count reaches zero.
// Assumes the active input is already normalized. Held at zero while disabled
// or on a polarity change.
module csep_integrator #(
    parameter int LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act,
    input  logic              enable,
    input  logic              clear,
    input  logic [LINE_W-1:0] line_period,
    output logic              v_out,
    output logic              v_pending
);
    logic [LINE_W-1:0] integ;
    logic [LINE_W-1:0] qtr;

    // Quarter-period threshold and the early vertical indication.
    always_comb begin
        qtr       = {2'b00, line_period[LINE_W-1:2]};
        v_pending = (integ > qtr);
    end

    // Integrate and apply the set/clear thresholds with hysteresis.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            integ <= '0;
            v_out <= 1'b0;
        end else if (!enable || clear) begin
            integ <= '0;
            v_out <= 1'b0;
        end else begin
            if (act && (integ < line_period))
                integ <= integ + LINE_W'(1);
            else if (!act && (integ != '0))
                integ <= integ - LINE_W'(1);
            if (integ > qtr)
                v_out <= 1'b1;
            else if (integ == '0)
                v_out <= 1'b0;
        end
    end
endmodule

// File: rtl/csep_edge_gate.sv
// Leading-edge gate.
// Emits a one-clock reference for each rising edge of the normalized sync that
// arrives at least line_period - line_period/4 clocks after the previous
// reference. During the vertical interval it also inserts a reference when a
// full line period passes without one. The elapsed-time counter saturates at
// line_period, and resets to its maximum so that the first edge is accepted.
module csep_edge_gate #(
    parameter int LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act,
    input  logic              enable,
    input  logic              v_active,
    input  logic [LINE_W-1:0] line_period,
    output logic              h_ref
);
    logic              act_q;
    logic [LINE_W-1:0] since_q;
    logic [LINE_W-1:0] holdoff;
    logic              rise;
    logic              accept;
    logic              insert;

    // Edge detection and the blanking/insertion decisions.
    always_comb begin
        holdoff = line_period - {2'b00, line_period[LINE_W-1:2]};
        rise    = act && !act_q;
        accept  = enable && rise && (since_q >= holdoff);
        insert  = enable && v_active && !accept && (since_q >= line_period);
    end

    // Register the reference and track time since the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q   <= 1'b0;
            since_q <= '1;
            h_ref   <= 1'b0;
        end else begin
            act_q <= act;
            h_ref <= accept || insert;
            if (accept || insert)
                since_q <= LINE_W'(1);
            else if (since_q < line_period)
                since_q <= since_q + LINE_W'(1);
        end
    end
endmodule

// File: rtl/comp_sync_sep.sv
// Composite sync separator top.
// Normalizes the sync polarity, then derives the horizontal reference and the
// extracted vertical interval from the normalized sync. It also keeps a flag
// that shows whether vertical sync was seen within the last MISS_LINES lines.
// Assumes sync_in is already synchronous to clk and line_period >= 4.
module comp_sync_sep #(
    parameter int LINE_W     = 12,
    parameter int MISS_LINES = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_in,
    input  logic [LINE_W-1:0] line_period,
    output logic              h_ref,
    output logic              v_sync,
    output logic              pol_neg,
    output logic              v_present
);
    import csep_pkg::*;

    localparam int MISS_W = $clog2(MISS_LINES + 1);

    pol_e              pol_sel;
    logic              pol_valid;
    logic              pol_flip;
    logic              act;
    logic              v_pending;
    logic              freeze;
    logic              v_q;
    logic [MISS_W-1:0] miss_cnt;

    // Normalize polarity and decide when the polarity may not change.
    always_comb begin
        pol_neg = (pol_sel == POL_LOW);
        act     = sync_in ^ pol_neg;
        freeze  = v_sync || v_pending;
    end

    csep_pol_detect #(.LINE_W(LINE_W)) u_pol (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_in     (sync_in),
        .line_period (line_period),
        .freeze      (freeze),
        .pol_sel     (pol_sel),
        .pol_valid   (pol_valid),
        .pol_flip    (pol_flip)
    );

    csep_integrator #(.LINE_W(LINE_W)) u_integ (
        .clk         (clk),
        .rst_n       (rst_n),
        .act         (act),
        .enable      (pol_valid),
        .clear       (pol_flip),
        .line_period (line_period),
        .v_out       (v_sync),
        .v_pending   (v_pending)
    );

    csep_edge_gate #(.LINE_W(LINE_W)) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .act         (act),
        .enable      (pol_valid),
        .v_active    (v_sync),
        .line_period (line_period),
        .h_ref       (h_ref)
    );

    // Presence flag: set on a new vertical, cleared after enough quiet lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q       <= 1'b0;
            v_present <= 1'b0;
            miss_cnt  <= '0;
        end else begin
            v_q <= v_sync;
            if (v_sync) begin
                miss_cnt <= '0;
                if (!v_q)
                    v_present <= 1'b1;
            end else if (h_ref && v_present) begin
                if (miss_cnt >= MISS_W'(MISS_LINES - 1)) begin
                    v_present <= 1'b0;
                    miss_cnt  <= '0;
                end else begin
                    miss_cnt <= miss_cnt + MISS_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/comp_sync_sep_chk.sv
// Assertion checker for comp_sync_sep, attached by bind.
// Keeps its own count of cycles between references so that the blanking
// window can be checked without a parameter-sized delay.
module comp_sync_sep_chk #(
    parameter int LINE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              h_ref,
    input logic              v_sync,
    input logic              pol_neg,
    input logic              v_present,
    input logic              pol_valid,
    input logic [LINE_W-1:0] line_period
);
    logic [LINE_W:0] gap;
    logic            seen;
    logic [LINE_W:0] hold;

    // Minimum spacing that blanking must guarantee.
    always_comb hold = {1'b0, line_period} - ({1'b0, line_period} >> 2);

    // Count cycles since the last reference pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (h_ref) begin
            gap  <= {{LINE_W{1'b0}}, 1'b1};
            seen <= 1'b1;
        end else if (gap != '1) begin
            gap <= gap + {{LINE_W{1'b0}}, 1'b1};
        end
    end

    // R4: reference is a single-cycle pulse.
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        h_ref |=> !h_ref);

    // R2: no output activity before the first polarity decision.
    a_r2_quiet_until_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !pol_valid |-> (!h_ref && !v_sync));

    // R3: polarity is held throughout the vertical interval.
    a_r3_pol_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        v_sync |=> $stable(pol_neg));

    // R9: presence flag follows a new vertical interval.
    a_r9_present_set: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(v_sync) |=> v_present);

    // R5: references are never closer than the blanking holdoff.
    a_r5_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (h_ref && seen) |-> (gap >= hold));
endmodule

bind comp_sync_sep comp_sync_sep_chk #(.LINE_W(LINE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .h_ref       (h_ref),
    .v_sync      (v_sync),
    .pol_neg     (pol_neg),
    .v_present   (v_present),
    .pol_valid   (pol_valid),
    .line_period (line_period)
);

// File: tb/comp_sync_sep_test.sv
// Directed bench for comp_sync_sep: one task per scenario, 64-clock lines.
module comp_sync_sep_test;
    localparam int LINE_W = 12;
    localparam int P      = 64;
    localparam int MISS   = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sync_in = 1'b0;
    logic [LINE_W-1:0] line_period = LINE_W'(P);
    logic              h_ref;
    logic              v_sync;
    logic              pol_neg;
    logic              v_present;

    int   checks = 0;
    int   errors = 0;
    int   href_cnt = 0;
    logic v_seen = 1'b0;
    logic act_lvl = 1'b1;

    always #2 clk = ~clk;

    comp_sync_sep #(.LINE_W(LINE_W), .MISS_LINES(MISS)) uut (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .line_period(line_period),
        .h_ref(h_ref), .v_sync(v_sync), .pol_neg(pol_neg), .v_present(v_present)
    );

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic do_reset(input logic lvl);
        act_lvl = lvl;
        rst_n   = 1'b0;
        sync_in = ~lvl;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sync_in = ~act_lvl;
        end
    endtask

    // One line: main pulse of width w at the start, optional extra pulse.
    task automatic run_line(input int w, input int eq_off, input int eq_w,
                            output logic aligned);
        aligned = 1'b0;
        for (int i = 0; i < P; i++) begin
            @(negedge clk);
            if (h_ref) href_cnt++;
            if (v_sync) v_seen = 1'b1;
            if (i == 1) aligned = h_ref;
            sync_in = ((i < w) || (eq_w > 0 && i >= eq_off && i < eq_off + eq_w))
                      ? act_lvl : ~act_lvl;
        end
    endtask

    task automatic t_reset;
        do_reset(1'b1);
        @(negedge clk);
        check("R1 h_ref", int'(h_ref), 0);
        check("R1 v_sync", int'(v_sync), 0);
        check("R1 pol_neg", int'(pol_neg), 0);
        check("R1 v_present", int'(v_present), 0);
    endtask

    task automatic t_startup;
        int h = 0;
        logic v = 1'b0;
        do_reset(1'b1);
        for (int i = 0; i < 56; i++) begin
            @(negedge clk);
            if (h_ref) h++;
            if (v_sync) v = 1'b1;
            sync_in = 1'b1;
        end
        check("R2 no h_ref before window", h, 0);
        check("R2 no v_sync before window", int'(v), 0);
    endtask

    task automatic t_positive;
        logic al;
        do_reset(1'b1);
        idle(80);
        check("R3 positive polarity", int'(pol_neg), 0);
        run_line(6, 0, 0, al);
        run_line(6, 0, 0, al);
        href_cnt = 0;
        for (int k = 0; k < 6; k++) begin
            run_line(6, 0, 0, al);
            check("R4 aligned positive", int'(al), 1);
        end
        check("R4 one per line positive", href_cnt, 6);
        check("R3 positive stays", int'(pol_neg), 0);
    endtask

    task automatic t_negative;
        logic al;
        do_reset(1'b0);
        idle(80);
        check("R3 negative polarity", int'(pol_neg), 1);
        run_line(6, 0, 0, al);
        href_cnt = 0;
        for (int k = 0; k < 6; k++) begin
            run_line(6, 0, 0, al);
            check("R4 aligned negative", int'(al), 1);
        end
        check("R4 one per line negative", href_cnt, 6);
        check("R3 negative stays", int'(pol_neg), 1);
    endtask

    task automatic t_equalize;
        logic al;
        do_reset(1'b1);
        idle(80);
        run_line(6, 0, 0, al);
        run_line(6, 0, 0, al);
        href_cnt = 0;
        v_seen   = 1'b0;
        for (int k = 0; k < 4; k++) begin
            run_line(6, 32, 3, al);
            check("R5 mid-line pulse blanked", int'(al), 1);
        end
        run_line(6, 47, 3, al);
        check("R5 one per line with equalization", href_cnt, 5);
        check("R5 no vertical from equalization", int'(v_seen), 0);
        href_cnt = 0;
        run_line(6, 48, 3, al);
        check("R5 edge at holdoff accepted", href_cnt, 2);
        run_line(6, 0, 0, al);
        check("R5 line edge blanked after late pulse", int'(al), 0);
        run_line(6, 0, 0, al);
        check("R5 edge accepted again", int'(al), 1);
    endtask

    task automatic t_width;
        logic al;
        do_reset(1'b1);
        idle(80);
        run_line(6, 0, 0, al);
        v_seen = 1'b0;
        for (int k = 0; k < 3; k++) run_line(16, 0, 0, al);
        check("R6 quarter width no vertical", int'(v_seen), 0);
        run_line(17, 0, 0, al);
        check("R6 wider pulse raises vertical", int'(v_seen), 1);
        check("R7 vertical drained", int'(v_sync), 0);
    endtask

    task automatic t_vertical;
        logic al;
        do_reset(1'b1);
        idle(80);
        for (int k = 0; k < 4; k++) run_line(6, 0, 0, al);
        href_cnt = 0;
        for (int k = 0; k < 3; k++) begin
            run_line(54, 0, 0, al);
            check("R4 broad pulse edge", int'(al), 1);
        end
        run_line(P, 0, 0, al);
        run_line(54, 0, 0, al);
        check("R8 synthesized reference", int'(al), 1);
        for (int k = 0; k < 2; k++) run_line(54, 0, 0, al);
        check("R8 one per line in vertical", href_cnt, 7);
        check("R6 vertical extracted", int'(v_sync), 1);
        check("R3 polarity frozen", int'(pol_neg), 0);
        check("R9 present set", int'(v_present), 1);
        for (int k = 0; k < 4; k++) run_line(6, 0, 0, al);
        check("R7 vertical ends", int'(v_sync), 0);
        check("R9 present held", int'(v_present), 1);
        for (int k = 0; k < 6; k++) run_line(6, 0, 0, al);
        check("R9 present cleared", int'(v_present), 0);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_startup();
        t_positive();
        t_negative();
        t_equalize();
        t_width();
        t_vertical();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule